// File: doc/BRIEF.md
# Serial Configuration Loader

This block loads a bitstream into a target device through a slave-serial configuration port. The port has three outputs: an active-low program strobe, a configuration clock and a data line. It also has two status inputs from the target, init and done. A one-cycle start request begins a reset handshake with the target. The block then takes configuration bytes from a valid/ready byte stream that carries a last-byte marker, and clocks them out one bit at a time. Finally it waits for the target to report that it is done.

Each of the three waits polls its status input on a millisecond grid. Each wait has its own timeout and its own error code. The millisecond is a parameter given in clock cycles. When the sequence ends, the block gives a signed 3-bit result and a one-cycle pulse. It then stays in its finished state until the next start.

The FSM states are:

- `ST_IDLE`: after reset.
- `ST_PROG_LOW`: program strobe driven low, waiting for init to fall.
- `ST_PROG_HIGH`: strobe released, waiting for init to rise.
- `ST_SHIFT`: bytes being shifted out.
- `ST_DONE_WAIT`: waiting for done.
- `ST_FINISH`: result held.

The transitions are:

- idle→prog_low on start.
- prog_low→prog_high when a poll sees init low.
- prog_high→shift when a poll sees init high.
- shift→done_wait after the final bit of the last-marked byte.
- done_wait→finish when a poll sees done high.
- prog_low, prog_high or done_wait→finish on timeout.
- finish→prog_low on start.

Top module: `cfg_serial_loader`

## Requirements
- R1: Out of reset, and in the idle and finished states, the program, clock and data outputs are all high, and busy and byte_ready are low.
- R2: A start in idle drives the program output low from the next cycle on. If no poll sees init low, the block finishes with result -1 (3'b111).
- R3: Once a poll sees init low, the program output returns high and the block waits for init high. If no poll sees init high, the block finishes with result -2 (3'b110).
- R4: In each wait state the status input is sampled in the first cycle of the state and then every CYC_PER_MS cycles, at polls 0 to POLL_LIMIT+1. At POLL_LIMIT+2 intervals after entry (5 by default) the wait fails without sampling. A status seen at the last poll still succeeds.
- R5: Every bit takes two cycles. In the first the clock is low and data carries the bit. In the second the clock is high and data is unchanged. Bits leave most significant first.
- R6: byte_ready is high only in the shift state while no byte is held. A byte is taken on a cycle with valid and ready both high. A valid input outside that case has no effect. Between bytes the clock and data outputs sit high.
- R7: After the final bit of a byte marked last, the block waits for done. A poll that sees done high finishes with result 0. A timeout finishes with result -3 (3'b101).
- R8: result_valid pulses for exactly the first cycle of the finished state. The result then stays stable until the next start, and a start clears it to 0.
- R9: A start while busy is ignored. A start in the finished state begins a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request (one cycle) |
| init_i | input | 1 | Target init status |
| done_i | input | 1 | Target done status |
| byte_data_i | input | 8 | Configuration byte |
| byte_valid_i | input | 1 | Byte valid |
| byte_last_i | input | 1 | Marks the final byte |
| byte_ready_o | output | 1 | Byte accepted when high with valid |
| prog_n_o | output | 1 | Program strobe, active low |
| cclk_o | output | 1 | Configuration clock |
| dout_o | output | 1 | Configuration data |
| busy_o | output | 1 | Sequence in progress |
| result_o | output | 3 | Signed result code |
| result_valid_o | output | 1 | One-cycle result pulse |

## Verification
All outputs are Moore outputs of registered state. A start shows on the program strobe one cycle later. An accepted byte puts its first bit on the data line in the next cycle, and the byte fills sixteen cycles after that. A wait that times out raises result_valid 5·CYC_PER_MS+1 cycles after the wait was entered. The bench model is updated on the same rising edge as the design and compared on the falling edge, so every output is checked in the cycle it is due. Status inputs are driven at chosen offsets, for example one just before and one just after the last poll, to exercise the poll boundary.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG_LOW,
        ST_PROG_HIGH,
        ST_SHIFT,
        ST_DONE_WAIT,
        ST_FINISH
    } cfgl_state_e;

    localparam int RES_W = 3;

    localparam logic signed [RES_W-1:0] RES_OK            = 3'sd0;
    localparam logic signed [RES_W-1:0] RES_INIT_LOW_TMO  = -3'sd1;
    localparam logic signed [RES_W-1:0] RES_INIT_HIGH_TMO = -3'sd2;
    localparam logic signed [RES_W-1:0] RES_DONE_TMO      = -3'sd3;

endpackage

// File: rtl/cfgl_poll_timer.sv
// Millisecond poll grid for the wait states (R4).
module cfgl_poll_timer #(
    parameter int CYC_PER_MS = 1000,
    parameter int POLL_LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic poll_now,
    output logic expired
);
    localparam int MS_W    = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam int FAIL_AT = POLL_LIMIT + 2;
    localparam int PW      = $clog2(FAIL_AT + 1);

    logic [MS_W-1:0] ms_q;
    logic [PW-1:0]   poll_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms_q   <= '0;
            poll_q <= '0;
        end else if (clr) begin
            ms_q   <= '0;
            poll_q <= '0;
        end else if (run) begin
            if (ms_q == MS_W'(CYC_PER_MS - 1)) begin
                ms_q <= '0;
                if (poll_q != PW'(FAIL_AT)) begin
                    poll_q <= poll_q + 1'b1;
                end
            end else begin
                ms_q <= ms_q + 1'b1;
            end
        end
    end

    assign poll_now = (ms_q == '0);
    assign expired  = poll_now && (poll_q == PW'(FAIL_AT));

endmodule

// File: rtl/cfgl_bit_shifter.sv
// Byte intake and MSB-first two-phase bit output (R5, R6).
module cfgl_bit_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              byte_valid,
    input  logic              byte_last,
    output logic              byte_ready,
    output logic              bit_clk,
    output logic              bit_data,
    output logic              final_bit
);
    localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

    logic [BYTE_W-1:0] sreg_q;
    logic [IDX_W-1:0]  idx_q;
    logic              half_q;
    logic              have_q;
    logic              last_q;
    logic              accept;

    assign byte_ready = en && !have_q;
    assign accept     = byte_ready && byte_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            idx_q  <= '0;
            half_q <= 1'b0;
            have_q <= 1'b0;
            last_q <= 1'b0;
        end else if (!en) begin
            have_q <= 1'b0;
            half_q <= 1'b0;
        end else if (accept) begin
            sreg_q <= byte_data;
            idx_q  <= '0;
            half_q <= 1'b0;
            have_q <= 1'b1;
            last_q <= byte_last;
        end else if (have_q) begin
            if (!half_q) begin
                half_q <= 1'b1;
            end else begin
                half_q <= 1'b0;
                sreg_q <= {sreg_q[BYTE_W-2:0], 1'b0};
                if (idx_q == IDX_W'(BYTE_W - 1)) begin
                    have_q <= 1'b0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // Line idles high between bytes; clock low then high per bit
    assign bit_clk   = have_q ? half_q : 1'b1;
    assign bit_data  = have_q ? sreg_q[BYTE_W-1] : 1'b1;
    assign final_bit = have_q && half_q && last_q && (idx_q == IDX_W'(BYTE_W - 1));

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfgl_pkg::*;
#(
    parameter int CYC_PER_MS = 100000,
    parameter int POLL_LIMIT = 3,
    parameter int BYTE_W     = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    init_i,
    input  logic                    done_i,
    input  logic [BYTE_W-1:0]       byte_data_i,
    input  logic                    byte_valid_i,
    input  logic                    byte_last_i,
    output logic                    byte_ready_o,
    output logic                    prog_n_o,
    output logic                    cclk_o,
    output logic                    dout_o,
    output logic                    busy_o,
    output logic signed [RES_W-1:0] result_o,
    output logic                    result_valid_o
);

    cfgl_state_e state_q, state_d;
    logic signed [RES_W-1:0] code_d;
    logic signed [RES_W-1:0] result_q;
    logic                    pulse_q;

    logic poll_now, expired, poll_clr, poll_run;
    logic sh_en, sh_clk, sh_data, sh_final;
    logic enter_finish, restart;

    assign poll_run = (state_q == ST_PROG_LOW) || (state_q == ST_PROG_HIGH) ||
                      (state_q == ST_DONE_WAIT);
    assign poll_clr = (state_d != state_q);
    assign sh_en    = (state_q == ST_SHIFT);

    cfgl_poll_timer #(
        .CYC_PER_MS (CYC_PER_MS),
        .POLL_LIMIT (POLL_LIMIT)
    ) u_poll (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (poll_clr),
        .run      (poll_run),
        .poll_now (poll_now),
        .expired  (expired)
    );

    cfgl_bit_shifter #(
        .BYTE_W (BYTE_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (sh_en),
        .byte_data  (byte_data_i),
        .byte_valid (byte_valid_i),
        .byte_last  (byte_last_i),
        .byte_ready (byte_ready_o),
        .bit_clk    (sh_clk),
        .bit_data   (sh_data),
        .final_bit  (sh_final)
    );

    // Next-state and result code
    always_comb begin
        state_d = state_q;
        code_d  = RES_OK;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_PROG_LOW;            // R9
            end
            ST_PROG_LOW: begin                                 // R2
                if (expired) begin
                    state_d = ST_FINISH;
                    code_d  = RES_INIT_LOW_TMO;
                end else if (poll_now && !init_i) begin
                    state_d = ST_PROG_HIGH;
                end
            end
            ST_PROG_HIGH: begin                                // R3
                if (expired) begin
                    state_d = ST_FINISH;
                    code_d  = RES_INIT_HIGH_TMO;
                end else if (poll_now && init_i) begin
                    state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (sh_final) state_d = ST_DONE_WAIT;
            end
            ST_DONE_WAIT: begin                                // R7
                if (expired) begin
                    state_d = ST_FINISH;
                    code_d  = RES_DONE_TMO;
                end else if (poll_now && done_i) begin
                    state_d = ST_FINISH;
                    code_d  = RES_OK;
                end
            end
            ST_FINISH: begin
                if (start_i) state_d = ST_PROG_LOW;            // R9
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign enter_finish = (state_d == ST_FINISH) && (state_q != ST_FINISH);
    assign restart      = ((state_q == ST_IDLE) || (state_q == ST_FINISH)) && start_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            result_q <= RES_OK;
            pulse_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pulse_q <= enter_finish;                           // R8
            if (restart) begin
                result_q <= RES_OK;
            end else if (enter_finish) begin
                result_q <= code_d;
            end
        end
    end

    // Outputs
    always_comb begin
        prog_n_o       = 1'b1;
        cclk_o         = 1'b1;
        dout_o         = 1'b1;
        busy_o         = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_FINISH: begin
                busy_o = 1'b0;                                 // R1
            end
            ST_PROG_LOW: begin
                prog_n_o = 1'b0;
                busy_o   = 1'b1;
            end
            ST_PROG_HIGH, ST_DONE_WAIT: begin
                busy_o = 1'b1;
            end
            ST_SHIFT: begin
                cclk_o = sh_clk;
                dout_o = sh_data;
                busy_o = 1'b1;
            end
            default: busy_o = 1'b0;
        endcase
        result_o       = result_q;
        result_valid_o = pulse_q;
    end

endmodule

// File: rtl/cfgl_checker.sv
module cfgl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       byte_ready_o,
    input logic       prog_n_o,
    input logic       cclk_o,
    input logic       dout_o,
    input logic       busy_o,
    input logic [2:0] result_o,
    input logic       result_valid_o
);

    // R1
    pins_high_when_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (prog_n_o && cclk_o && dout_o));

    // R2
    prog_low_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n_o |-> busy_o);

    // R5
    data_held_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $rose(cclk_o)) |-> $stable(dout_o));

    // R6
    ready_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready_o |-> (busy_o && prog_n_o));

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid_o |=> !result_valid_o);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(result_o));

endmodule

bind cfg_serial_loader cfgl_checker u_cfgl_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .byte_ready_o   (byte_ready_o),
    .prog_n_o       (prog_n_o),
    .cclk_o         (cclk_o),
    .dout_o         (dout_o),
    .busy_o         (busy_o),
    .result_o       (result_o),
    .result_valid_o (result_valid_o)
);

// File: tb/cfg_serial_loader_bench.sv
module cfg_serial_loader_bench;
    localparam int MS = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic init_i = 1'b1;
    logic done_i = 1'b0;
    logic [7:0] byte_data_i = 8'h00;
    logic byte_valid_i = 1'b0;
    logic byte_last_i = 1'b0;
    logic byte_ready_o, prog_n_o, cclk_o, dout_o, busy_o, result_valid_o;
    logic signed [2:0] result_o;

    always #5 clk = ~clk;

    cfg_serial_loader #(.CYC_PER_MS(MS), .POLL_LIMIT(3), .BYTE_W(8)) u_cfg_serial_loader (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .init_i(init_i), .done_i(done_i),
        .byte_data_i(byte_data_i), .byte_valid_i(byte_valid_i), .byte_last_i(byte_last_i),
        .byte_ready_o(byte_ready_o), .prog_n_o(prog_n_o), .cclk_o(cclk_o), .dout_o(dout_o),
        .busy_o(busy_o), .result_o(result_o), .result_valid_o(result_valid_o)
    );

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    task automatic check(string req, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Target emulation: init falls lo_dly negedges into program low, rises hi_dly after release
    int lo_dly = 0, hi_dly = 0, lo_cnt = 0, hi_cnt = 0;
    always @(negedge clk) begin
        if (!prog_n_o) begin
            hi_cnt = 0;
            if (lo_dly >= 0) begin
                if (lo_cnt >= lo_dly) init_i <= 1'b0;
                lo_cnt++;
            end
        end else begin
            lo_cnt = 0;
            if (hi_dly >= 0) begin
                if (hi_cnt >= hi_dly) init_i <= 1'b1;
                hi_cnt++;
            end
        end
    end

    // Reference model: 0 idle, 1 prog low, 2 prog high, 3 shift, 4 done wait, 5 finished
    int m_st = 0, m_t = 0, m_res = 0;
    bit m_q[$];
    bit m_half = 0, m_last = 0, m_pulse = 0;

    task automatic m_finish(int code);
        m_st = 5; m_res = code; m_pulse = 1;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_t = 0; m_res = 0; m_q.delete(); m_half = 0; m_pulse = 0;
        end else begin
            m_pulse = 0;
            case (m_st)
                0, 5: if (start_i) begin m_st = 1; m_t = 0; m_res = 0; end
                1, 2, 4: begin
                    bit cond;
                    int prev;
                    prev = m_st;
                    cond = (m_st == 1) ? !init_i : (m_st == 2) ? init_i : done_i;
                    if (m_t % MS == 0) begin
                        if (m_t / MS >= 5) m_finish(m_st == 1 ? -1 : m_st == 2 ? -2 : -3);
                        else if (cond) begin
                            if (m_st == 4) m_finish(0);
                            else if (m_st == 1) begin m_st = 2; m_t = 0; end
                            else begin m_st = 3; m_q.delete(); m_half = 0; end
                        end
                    end
                    if (m_st == prev) m_t++;
                end
                3: begin
                    if (m_q.size() == 0) begin
                        if (byte_valid_i) begin
                            for (int b = 7; b >= 0; b--) m_q.push_back(byte_data_i[b]);
                            m_half = 0; m_last = byte_last_i;
                        end
                    end else if (!m_half) m_half = 1;
                    else begin
                        void'(m_q.pop_front());
                        m_half = 0;
                        if (m_q.size() == 0 && m_last) begin m_st = 4; m_t = 0; end
                    end
                end
                default: m_st = 0;
            endcase
        end
    end

    // Per-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit sh;
            sh = (m_st == 3) && (m_q.size() > 0);
            check("R2", "prog_n", prog_n_o, (m_st == 1) ? 0 : 1);
            check("R5", "cclk", cclk_o, sh ? m_half : 1);
            check("R5", "dout", dout_o, sh ? m_q[0] : 1);
            check("R6", "byte_ready", byte_ready_o, (m_st == 3 && m_q.size() == 0) ? 1 : 0);
            check("R9", "busy", busy_o, (m_st >= 1 && m_st <= 4) ? 1 : 0);
            check("R8", "result_valid", result_valid_o, m_pulse);
            check("R8", "result", int'(result_o), m_res);
        end
    end

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic send_byte(logic [7:0] d, bit last, int gap);
        repeat (gap) @(negedge clk);
        byte_valid_i = 1'b1; byte_data_i = d; byte_last_i = last;
        while (!byte_ready_o) @(negedge clk);
        @(negedge clk);
        byte_valid_i = 1'b0; byte_last_i = 1'b0;
    endtask

    task automatic wait_result(string req, int exp);
        int n = 0;
        while (!result_valid_o && n < 3000) begin @(negedge clk); n++; end
        check(req, "final result", int'(result_o), exp);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            compared++; mismatched++;
            $display("FAIL watchdog expired, actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "prog_n", prog_n_o, 1);
        check("R1", "cclk", cclk_o, 1);
        check("R1", "dout", dout_o, 1);
        check("R1", "busy", busy_o, 0);
        check("R1", "byte_ready", byte_ready_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 valid while idle is ignored
        byte_valid_i = 1'b1; byte_data_i = 8'h5A;
        repeat (3) @(negedge clk);
        check("R6", "ready idle", byte_ready_o, 0);
        check("R6", "busy idle", busy_o, 0);
        byte_valid_i = 1'b0;

        // Normal load with a start during busy (R9), gaps between bytes (R6)
        lo_dly = 3; hi_dly = 5;
        pulse_start();
        check("R2", "prog low after start", prog_n_o, 0);
        pulse_start();
        send_byte(8'hA5, 0, 0);
        send_byte(8'h3C, 0, 3);
        send_byte(8'h81, 1, 5);
        repeat (16 + 6) @(negedge clk);
        done_i = 1'b1;
        wait_result("R7", 0);
        check("R9", "idle after finish", busy_o, 0);
        done_i = 1'b0;

        // R2 init never falls -> -1, restart from finished state (R9)
        lo_dly = -1;
        pulse_start();
        wait_result("R2", -1);
        check("R4", "no busy after timeout", busy_o, 0);

        // R3 init never rises -> -2
        lo_dly = 2; hi_dly = -1;
        pulse_start();
        wait_result("R3", -2);

        // R7 done never rises -> -3
        hi_dly = 3;
        pulse_start();
        send_byte(8'hFF, 0, 0);
        send_byte(8'h00, 1, 1);
        wait_result("R7", -3);

        // R4 done seen at the last poll -> success
        pulse_start();
        send_byte(8'h96, 1, 0);
        repeat (16 + 3 * MS + 2) @(negedge clk);
        done_i = 1'b1;
        wait_result("R4", 0);
        done_i = 1'b0;

        // R4 done one cycle after the last poll -> timeout
        pulse_start();
        send_byte(8'h6E, 1, 2);
        repeat (16 + 4 * MS + 1) @(negedge clk);
        done_i = 1'b1;
        wait_result("R4", -3);
        done_i = 1'b0;

        repeat (4) @(negedge clk);
        check("R8", "result held", int'(result_o), -3);
        check("R1", "pins high finished", int'({prog_n_o, cclk_o, dout_o}), 7);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule